// File: doc/BRIEF.md
# Write-Update Shared Line Coherence Controller

This block tracks the coherence state of one shared-data cache line on the requesting side of a node that keeps separate private and shared caches. It has three neighbours: the local processor, a snooping coherence bus that all shared-cache controllers watch, and a block-transfer port to memory whose latency is variable and unbounded. Copies held in other caches are kept consistent by broadcasting updates. No copy is ever invalidated.

The line carries a valid bit plus three state bits: transient, modified and exclusive. The transient bit stays set while a fetch or a write-back is in flight through the network, and no processor access can complete during that time. On a miss the controller puts a block-check on the bus and then acts on the reply. With no remote copy it fetches from memory. If a remote copy is still in transit it retries after a programmable delay. If a remote copy is dirty it waits for the remote write-back to finish, and then fetches. Once the line is Permanent, the stalled processor access completes as an ordinary hit. Write hits on a shared line broadcast an update. On eviction, a modified line is written back before its entry is dropped.

Top module: `wu_line_ctrl`

## Requirements
- R1: After reset the line is invalid (`line_valid`=0) and `cpu_ready`, `evict_ready`, `bus_cmd_valid` and `mem_req_valid` are all low. The bits of `line_state` are [2]=transient, [1]=modified, [0]=exclusive.
- R2: While the line is valid and transient, `cpu_ready` stays low.
- R3: A read on a valid Permanent line completes in the cycle it is presented (`cpu_ready`=1), and it leaves `line_valid` and `line_state` unchanged.
- R4: A read on an invalid line first issues a block-check (`bus_cmd`=2'b01). The reply `bus_rsp`=2'b00 means no other cache holds the line. On that reply the line becomes 3'b100 and a fetch is requested (`mem_req_wr`=0). On `mem_ack` the line becomes 3'b001 and the read then completes.
- R5: The reply 2'b01 means a remote copy is in transit. On it the controller re-issues the block-check exactly RETRY_CYCLES cycles after the reply cycle, and requests no memory traffic in between.
- R6: On a read miss, the reply 2'b10 means a clean Permanent remote copy. On it the line becomes 3'b100, is fetched, and ends 3'b000 (not exclusive).
- R7: The reply 2'b11 means a dirty remote copy. On it the line becomes transient, and the fetch is not requested until `bus_wb_done` has been seen. After that the fetch proceeds as in R6.
- R8: Write hits: 3'b011 and 3'b001 both end in 3'b011 with no bus command and complete at once. 3'b000 and 3'b010 issue an update (`bus_cmd`=2'b10), complete in the cycle the update is accepted, and end in 3'b010.
- R9: A write miss with reply 2'b00 puts the line in 3'b110, fetches it, and ends in 3'b011.
- R10: A write miss with reply 2'b10 puts the line in 3'b110 and fetches it. The line then ends in 3'b010, and an update broadcast completes the write.
- R11: Eviction of a modified line sets 3'b110 and requests a write-back (`mem_req_wr`=1). `evict_ready` rises and the entry drops only with `mem_ack`. An unmodified or invalid line is dropped at once with no bus or memory request.
- R12: An eviction presented in the same cycle as a processor access is served first, and the access then runs as a miss. A bus command and a memory request are never active together, and each is held stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor access present, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_ready | output | 1 | Access completes at this clock edge |
| evict_valid | input | 1 | Replacement of this line requested, held until `evict_ready` |
| evict_ready | output | 1 | Replacement completes at this clock edge |
| bus_cmd_valid | output | 1 | Bus command presented |
| bus_cmd | output | 2 | 2'b01 block-check, 2'b10 update broadcast |
| bus_cmd_ready | input | 1 | Bus grant: command accepted at this edge |
| bus_rsp_valid | input | 1 | Block-check reply present |
| bus_rsp | input | 2 | 00 none, 01 transient copy, 10 clean copy, 11 dirty copy |
| bus_wb_done | input | 1 | Remote write-back completed |
| mem_req_valid | output | 1 | Memory transfer request presented |
| mem_req_wr | output | 1 | 1 = write-back, 0 = fetch |
| mem_req_ready | input | 1 | Memory request accepted at this edge |
| mem_ack | input | 1 | Memory transfer finished (data arrived or write-back done) |
| line_valid | output | 1 | Directory entry present |
| line_state | output | 3 | {transient, modified, exclusive} |

## Verification
An eviction request and a processor access can reach the idle controller in the same cycle, and the two compete for the same state transition. The bench raises both together while the line is Modified-Exclusive. It checks that `cpu_ready` stays low, that a write-back rather than a block-check comes out, and that the entry drops on the memory acknowledgement. The held read must then start over as a miss and complete only after a fresh fetch. A second pairing checks that an update command held by a busy bus keeps the processor write stalled, and that the write completes in the very cycle the bus grants.

// File: rtl/wu_line_pkg.sv
package wu_line_pkg;

   typedef struct packed {
      logic trans;
      logic modif;
      logic excl;
   } line_st_t;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'b00,
      CMD_CHECK  = 2'b01,
      CMD_UPDATE = 2'b10
   } bus_cmd_e;

   typedef enum logic [1:0] {
      RSP_NOCOPY = 2'b00,
      RSP_TRANS  = 2'b01,
      RSP_CLEAN  = 2'b10,
      RSP_DIRTY  = 2'b11
   } bus_rsp_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CHECK,
      S_SNOOP,
      S_RETRY,
      S_WBWAIT,
      S_FETCH,
      S_FILL,
      S_UPDATE,
      S_WBACK,
      S_WBACK_ACK
   } seq_e;

   typedef enum logic [2:0] {
      A_NONE,
      A_EVICT_DROP,
      A_EVICT_WB,
      A_READ_HIT,
      A_WRITE_LOCAL,
      A_WRITE_BCAST,
      A_MISS
   } act_e;

endpackage

// File: rtl/wu_retry_timer.sv
module wu_retry_timer #(
   parameter int unsigned RETRY_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned CNT_W = $clog2(RETRY_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_CYCLES - 1);

   generate
      if (RETRY_CYCLES < 1) begin : g_bad_retry
         $error("wu_retry_timer: RETRY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign done = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || done) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wu_hit_decode.sv
module wu_hit_decode
   import wu_line_pkg::*;
(
   input  logic     line_valid,
   input  line_st_t line_st,
   input  logic     cpu_valid,
   input  logic     cpu_write,
   input  logic     evict_valid,
   output act_e     act
);
   always_comb begin
      act = A_NONE;
      if (evict_valid) begin
         if (line_valid && line_st.modif) act = A_EVICT_WB;
         else                             act = A_EVICT_DROP;
      end else if (cpu_valid) begin
         if (!line_valid) begin
            act = A_MISS;
         end else if (line_st.trans) begin
            act = A_NONE;
         end else if (!cpu_write) begin
            act = A_READ_HIT;
         end else if (line_st.excl) begin
            act = A_WRITE_LOCAL;
         end else begin
            act = A_WRITE_BCAST;
         end
      end
   end
endmodule

// File: rtl/wu_line_seq.sv
module wu_line_seq
   import wu_line_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  act_e       act,
   input  logic       cpu_valid,
   input  logic       cpu_write,
   input  logic       bus_cmd_ready,
   input  logic       bus_rsp_valid,
   input  logic [1:0] bus_rsp,
   input  logic       bus_wb_done,
   input  logic       mem_req_ready,
   input  logic       mem_ack,
   input  logic       retry_done,
   output logic       retry_run,
   output logic       cpu_ready,
   output logic       evict_ready,
   output logic       bus_cmd_valid,
   output logic [1:0] bus_cmd,
   output logic       mem_req_valid,
   output logic       mem_req_wr,
   output logic       line_valid,
   output line_st_t   line_st
);
   seq_e st;
   logic wr_q;
   logic remote_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         line_valid <= 1'b0;
         line_st    <= '0;
         wr_q       <= 1'b0;
         remote_q   <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               case (act)
                  A_EVICT_DROP: begin
                     line_valid <= 1'b0;
                     line_st    <= '0;
                  end
                  A_EVICT_WB: begin
                     line_st <= '{trans: 1'b1, modif: 1'b1, excl: 1'b0};
                     st      <= S_WBACK;
                  end
                  A_WRITE_LOCAL: line_st <= '{trans: 1'b0, modif: 1'b1, excl: 1'b1};
                  A_WRITE_BCAST: st <= S_UPDATE;
                  A_MISS: begin
                     wr_q <= cpu_write;
                     st   <= S_CHECK;
                  end
                  default: ;
               endcase
            end
            S_CHECK: if (bus_cmd_ready) st <= S_SNOOP;
            S_SNOOP: begin
               if (bus_rsp_valid) begin
                  if (bus_rsp == RSP_TRANS) begin
                     st <= S_RETRY;
                  end else begin
                     line_valid <= 1'b1;
                     line_st    <= '{trans: 1'b1, modif: wr_q, excl: 1'b0};
                     remote_q   <= (bus_rsp != RSP_NOCOPY);
                     st         <= (bus_rsp == RSP_DIRTY) ? S_WBWAIT : S_FETCH;
                  end
               end
            end
            S_RETRY:  if (retry_done)    st <= S_CHECK;
            S_WBWAIT: if (bus_wb_done)   st <= S_FETCH;
            S_FETCH:  if (mem_req_ready) st <= S_FILL;
            S_FILL: begin
               if (mem_ack) begin
                  line_st <= '{trans: 1'b0, modif: wr_q, excl: !remote_q};
                  st      <= S_IDLE;
               end
            end
            S_UPDATE: begin
               if (bus_cmd_ready) begin
                  line_st <= '{trans: 1'b0, modif: 1'b1, excl: 1'b0};
                  st      <= S_IDLE;
               end
            end
            S_WBACK: if (mem_req_ready) st <= S_WBACK_ACK;
            S_WBACK_ACK: begin
               if (mem_ack) begin
                  line_valid <= 1'b0;
                  line_st    <= '0;
                  st         <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign retry_run     = (st == S_RETRY);
   assign bus_cmd_valid = (st == S_CHECK) || (st == S_UPDATE);
   assign bus_cmd       = (st == S_UPDATE) ? CMD_UPDATE :
                          (st == S_CHECK)  ? CMD_CHECK  : CMD_NONE;
   assign mem_req_valid = (st == S_FETCH) || (st == S_WBACK);
   assign mem_req_wr    = (st == S_WBACK);

   assign cpu_ready   = ((st == S_IDLE) && ((act == A_READ_HIT) || (act == A_WRITE_LOCAL)))
                     || ((st == S_UPDATE) && cpu_valid && bus_cmd_ready);
   assign evict_ready = ((st == S_IDLE) && (act == A_EVICT_DROP))
                     || ((st == S_WBACK_ACK) && mem_ack);
endmodule

// File: rtl/wu_line_ctrl.sv
module wu_line_ctrl
   import wu_line_pkg::*;
#(
   parameter int unsigned RETRY_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_valid,
   input  logic       cpu_write,
   output logic       cpu_ready,
   input  logic       evict_valid,
   output logic       evict_ready,
   output logic       bus_cmd_valid,
   output logic [1:0] bus_cmd,
   input  logic       bus_cmd_ready,
   input  logic       bus_rsp_valid,
   input  logic [1:0] bus_rsp,
   input  logic       bus_wb_done,
   output logic       mem_req_valid,
   output logic       mem_req_wr,
   input  logic       mem_req_ready,
   input  logic       mem_ack,
   output logic       line_valid,
   output logic [2:0] line_state
);
   act_e     act;
   line_st_t line_st;
   logic     retry_run;
   logic     retry_done;

   wu_hit_decode u_decode (
      .line_valid  (line_valid),
      .line_st     (line_st),
      .cpu_valid   (cpu_valid),
      .cpu_write   (cpu_write),
      .evict_valid (evict_valid),
      .act         (act)
   );

   wu_retry_timer #(.RETRY_CYCLES(RETRY_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (retry_run),
      .done  (retry_done)
   );

   wu_line_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .act           (act),
      .cpu_valid     (cpu_valid),
      .cpu_write     (cpu_write),
      .bus_cmd_ready (bus_cmd_ready),
      .bus_rsp_valid (bus_rsp_valid),
      .bus_rsp       (bus_rsp),
      .bus_wb_done   (bus_wb_done),
      .mem_req_ready (mem_req_ready),
      .mem_ack       (mem_ack),
      .retry_done    (retry_done),
      .retry_run     (retry_run),
      .cpu_ready     (cpu_ready),
      .evict_ready   (evict_ready),
      .bus_cmd_valid (bus_cmd_valid),
      .bus_cmd       (bus_cmd),
      .mem_req_valid (mem_req_valid),
      .mem_req_wr    (mem_req_wr),
      .line_valid    (line_valid),
      .line_st       (line_st)
   );

   assign line_state = line_st;
endmodule

// File: rtl/wu_line_ctrl_chk.sv
module wu_line_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_valid,
   input logic       cpu_write,
   input logic       cpu_ready,
   input logic       bus_cmd_valid,
   input logic [1:0] bus_cmd,
   input logic       bus_cmd_ready,
   input logic       bus_rsp_valid,
   input logic [1:0] bus_rsp,
   input logic       bus_wb_done,
   input logic       mem_req_valid,
   input logic       mem_req_wr,
   input logic       mem_req_ready,
   input logic       line_valid,
   input logic [2:0] line_state
);
   logic dirty_wait;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   dirty_wait <= 1'b0;
      else if (bus_wb_done)                         dirty_wait <= 1'b0;
      else if (bus_rsp_valid && bus_rsp == 2'b11)   dirty_wait <= 1'b1;
   end

   a_r2_stall_transient: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid && line_state[2]) |-> !cpu_ready);

   a_r3_read_hit_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && !cpu_write) |=> ($stable(line_state) && $stable(line_valid)));

   a_r4_fetch_is_transient: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_wr) |-> (line_valid && line_state[2]));

   a_r7_fetch_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_wait |-> !mem_req_valid);

   a_r8_exclusive_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && cpu_write && line_valid && line_state[0]) |-> !bus_cmd_valid);

   a_r11_wb_only_modified: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_wr) |-> (line_valid && line_state == 3'b110));

   a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_cmd_valid && mem_req_valid));

   a_r12_bus_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_valid && !bus_cmd_ready) |=> (bus_cmd_valid && $stable(bus_cmd)));

   a_r12_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_wr)));
endmodule

bind wu_line_ctrl wu_line_ctrl_chk u_chk (.*);

// File: tb/tb_wu_line_ctrl.sv
module tb_wu_line_ctrl;
   localparam int RETRY = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cpu_valid, cpu_write, cpu_ready;
   logic       evict_valid, evict_ready;
   logic       bus_cmd_valid, bus_cmd_ready;
   logic [1:0] bus_cmd;
   logic       bus_rsp_valid, bus_wb_done;
   logic [1:0] bus_rsp;
   logic       mem_req_valid, mem_req_wr, mem_req_ready, mem_ack;
   logic       line_valid;
   logic [2:0] line_state;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   wu_line_ctrl #(.RETRY_CYCLES(RETRY)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_ready(cpu_ready),
      .evict_valid(evict_valid), .evict_ready(evict_ready),
      .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_cmd_ready(bus_cmd_ready),
      .bus_rsp_valid(bus_rsp_valid), .bus_rsp(bus_rsp), .bus_wb_done(bus_wb_done),
      .mem_req_valid(mem_req_valid), .mem_req_wr(mem_req_wr),
      .mem_req_ready(mem_req_ready), .mem_ack(mem_ack),
      .line_valid(line_valid), .line_state(line_state)
   );

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   task automatic wait_bus(string tag);
      int n = 0;
      while (!bus_cmd_valid && n < 40) begin step(); n++; end
      chk(tag, bus_cmd_valid, 1);
   endtask

   task automatic wait_mem(string tag);
      int n = 0;
      while (!mem_req_valid && n < 40) begin step(); n++; end
      chk(tag, mem_req_valid, 1);
   endtask

   task automatic bus_answer(logic [1:0] code);
      bus_rsp_valid = 1'b1;
      bus_rsp       = code;
      step();
      bus_rsp_valid = 1'b0;
      #1;
   endtask

   task automatic mem_answer;
      mem_ack = 1'b1;
      step();
      mem_ack = 1'b0;
      #1;
   endtask

   task automatic miss_start(logic wr, string tag);
      cpu_valid = 1'b1;
      cpu_write = wr;
      wait_bus(tag);
      chk({tag, " check cmd"}, bus_cmd, 2'b01);
      step();
   endtask

   task automatic finish_access(string tag);
      chk(tag, cpu_ready, 1);
      step();
      cpu_valid = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      chk("R1 valid", line_valid, 0);
      chk("R1 cpu_ready", cpu_ready, 0);
      chk("R1 evict_ready", evict_ready, 0);
      chk("R1 bus_cmd_valid", bus_cmd_valid, 0);
      chk("R1 mem_req_valid", mem_req_valid, 0);
   endtask

   task automatic t_read_miss_nocopy;
      cpu_valid = 1'b1; cpu_write = 1'b0; #1;
      chk("R4 miss not ready", cpu_ready, 0);
      miss_start(1'b0, "R4");
      bus_answer(2'b00);
      chk("R4 state transient", {line_valid, line_state}, 4'b1100);
      chk("R2 stall in transient", cpu_ready, 0);
      chk("R4 fetch issued", {mem_req_valid, mem_req_wr}, 2'b10);
      step();
      chk("R2 stall during fill", cpu_ready, 0);
      mem_answer();
      chk("R4 state after fill", line_state, 3'b001);
      finish_access("R4 read completes");
   endtask

   task automatic t_hits_exclusive;
      cpu_valid = 1'b1; cpu_write = 1'b0; #1;
      chk("R3 read hit ready", cpu_ready, 1);
      step();
      chk("R3 read hit state", {line_valid, line_state}, 4'b1001);
      cpu_write = 1'b1; #1;
      chk("R8 UE write ready", cpu_ready, 1);
      chk("R8 UE write no bus", bus_cmd_valid, 0);
      step();
      chk("R8 UE becomes ME", line_state, 3'b011);
      chk("R8 ME write ready", cpu_ready, 1);
      step();
      chk("R8 ME write quiet", bus_cmd_valid, 0);
      chk("R8 ME stays", line_state, 3'b011);
      cpu_valid = 1'b0; #1;
   endtask

   task automatic evict_modified(string tag);
      evict_valid = 1'b1; #1;
      chk({tag, " not done yet"}, evict_ready, 0);
      step();
      chk({tag, " writeback req"}, {mem_req_valid, mem_req_wr}, 2'b11);
      chk({tag, " state during wb"}, {line_valid, line_state}, 4'b1110);
      step();
      chk({tag, " wait ack"}, evict_ready, 0);
      mem_ack = 1'b1; #1;
      chk({tag, " ready with ack"}, evict_ready, 1);
      step();
      mem_ack = 1'b0; evict_valid = 1'b0; #1;
      chk({tag, " entry dropped"}, line_valid, 0);
   endtask

   task automatic t_retry_then_clean;
      int n = 0;
      miss_start(1'b0, "R5");
      bus_answer(2'b01);
      while (!bus_cmd_valid && n < 50) begin
         if (mem_req_valid) chk("R5 no memory during retry", mem_req_valid, 0);
         step(); n++;
      end
      chk("R5 retry delay", 8'(n), 8'(RETRY));
      chk("R5 recheck cmd", bus_cmd, 2'b01);
      step();
      bus_answer(2'b10);
      chk("R6 state transient", {line_valid, line_state}, 4'b1100);
      wait_mem("R6 fetch");
      step();
      mem_answer();
      chk("R6 ends UNE", {line_valid, line_state}, 4'b1000);
      finish_access("R6 read completes");
   endtask

   task automatic t_write_bcast_held;
      bus_cmd_ready = 1'b0;
      cpu_valid = 1'b1; cpu_write = 1'b1; #1;
      chk("R8 UNE write waits", cpu_ready, 0);
      step();
      chk("R8 update cmd", {bus_cmd_valid, bus_cmd}, 3'b110);
      chk("R8 stall while not granted", cpu_ready, 0);
      step();
      chk("R12 update held", {bus_cmd_valid, bus_cmd}, 3'b110);
      chk("R12 no mem while bus busy", mem_req_valid, 0);
      bus_cmd_ready = 1'b1; #1;
      chk("R8 done on grant", cpu_ready, 1);
      step();
      cpu_valid = 1'b0; #1;
      chk("R8 ends MNE", line_state, 3'b010);
      chk("R8 bus idle after", bus_cmd_valid, 0);
   endtask

   task automatic t_read_miss_dirty;
      miss_start(1'b0, "R7");
      bus_answer(2'b11);
      chk("R7 state transient", {line_valid, line_state}, 4'b1100);
      for (int i = 0; i < 3; i++) begin
         chk("R7 fetch held back", mem_req_valid, 0);
         step();
      end
      bus_wb_done = 1'b1;
      step();
      bus_wb_done = 1'b0; #1;
      chk("R7 fetch after wb_done", {mem_req_valid, mem_req_wr}, 2'b10);
      step();
      mem_answer();
      chk("R7 ends UNE", line_state, 3'b000);
      finish_access("R7 read completes");
   endtask

   task automatic evict_clean(string tag);
      evict_valid = 1'b1; #1;
      chk({tag, " immediate"}, evict_ready, 1);
      chk({tag, " no traffic"}, {bus_cmd_valid, mem_req_valid}, 2'b00);
      step();
      evict_valid = 1'b0; #1;
      chk({tag, " dropped"}, line_valid, 0);
      chk({tag, " still quiet"}, {bus_cmd_valid, mem_req_valid}, 2'b00);
   endtask

   task automatic t_write_miss_nocopy;
      miss_start(1'b1, "R9");
      bus_answer(2'b00);
      chk("R9 state MT", {line_valid, line_state}, 4'b1110);
      chk("R9 fetch", {mem_req_valid, mem_req_wr}, 2'b10);
      step();
      mem_answer();
      chk("R9 ends ME", line_state, 3'b011);
      chk("R9 no update", bus_cmd_valid, 0);
      finish_access("R9 write completes");
   endtask

   task automatic t_evict_vs_access;
      cpu_valid = 1'b1; cpu_write = 1'b0; evict_valid = 1'b1; #1;
      chk("R12 access loses to evict", cpu_ready, 0);
      step();
      chk("R12 writeback first", {mem_req_valid, mem_req_wr, bus_cmd_valid}, 3'b110);
      step();
      mem_ack = 1'b1; #1;
      chk("R12 evict done", evict_ready, 1);
      step();
      mem_ack = 1'b0; evict_valid = 1'b0; #1;
      chk("R12 access now a miss", cpu_ready, 0);
      wait_bus("R12 miss check");
      chk("R12 check cmd", bus_cmd, 2'b01);
      step();
      bus_answer(2'b00);
      wait_mem("R12 fetch");
      step();
      mem_answer();
      chk("R12 refilled UE", line_state, 3'b001);
      finish_access("R12 read completes");
   endtask

   task automatic t_write_miss_clean;
      miss_start(1'b1, "R10");
      bus_answer(2'b10);
      chk("R10 state MT", {line_valid, line_state}, 4'b1110);
      wait_mem("R10 fetch");
      step();
      mem_answer();
      chk("R10 state MNE", {line_valid, line_state}, 4'b1010);
      chk("R10 not done before update", cpu_ready, 0);
      step();
      chk("R10 update cmd", {bus_cmd_valid, bus_cmd}, 3'b110);
      finish_access("R10 write completes on update");
      chk("R10 ends MNE", line_state, 3'b010);
   endtask

   initial begin
      rst_n = 1'b0;
      cpu_valid = 0; cpu_write = 0; evict_valid = 0;
      bus_cmd_ready = 1; bus_rsp_valid = 0; bus_rsp = 0; bus_wb_done = 0;
      mem_req_ready = 1; mem_ack = 0;
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_read_miss_nocopy();
      t_hits_exclusive();
      evict_modified("R11 ME");
      t_retry_then_clean();
      t_write_bcast_held();
      evict_modified("R11 MNE");
      t_read_miss_dirty();
      evict_clean("R11 UNE");
      t_write_miss_nocopy();
      t_evict_vs_access();
      evict_clean("R11 UE");
      evict_clean("R11 invalid");
      t_write_miss_clean();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule